// File: doc/BRIEF.md
# Segment-Partitioned Masked Associative Memory

This block holds a small table of 64-bit words and searches all of them at once against a 64-bit search key. Each word is cut into four 16-bit segments. A runtime split setting decides how many of the upper segments are searched; this is the key part. The remaining lower segments are payload that is carried along and never compared. A global 64-bit care mask can also exclude single bits from the search. Only words whose valid flag is set can take part in a hit.

A search is started with a one-cycle strobe. One clock later the block presents a hit flag, a flag that says more than one word hit, the index of the lowest-numbered word that hit, and that word's payload segments. In the payload output the key segments are cleared. The host fills the table by writing a word and its valid flag to an index. It can read any word back by index on a combinational read port. The split setting, the care mask and the search key are each held in a register that is loaded by its own strobe.

Top module: `cam_partitioned`

## Requirements
- R1: After reset every word is invalid (rd_valid is 0), the care mask is all ones, the split code is 4, the search key is zero, and match, multi, match_addr and match_ram are all 0.
- R2: When wr_en is high at a clock edge, wr_data and wr_valid are stored at wr_addr. From the following cycle rd_data and rd_valid show that word whenever rd_addr selects it.
- R3: Search results change only at an edge where cmp_go is high. They are computed from the table, key, mask and split as they stood just before that edge, so a write or register load at the same edge is not seen. Without cmp_go the results hold.
- R4: An invalid word never produces a hit, even when its contents equal the key.
- R5: Split code n, for n from 1 to 4, compares the top n segments, which are bits 63 down to 64−16n. Code 0 behaves as code 1, and codes 5, 6 and 7 behave as code 4.
- R6: A care-mask bit of 1 includes that bit in the search and a bit of 0 excludes it. A bit is compared only if it is both in a key segment and set in the mask. When no bit is compared, every valid word hits.
- R7: When several valid words hit, match_addr gives the lowest index among them.
- R8: multi is 1 exactly when two or more valid words hit, and it is never 1 without match.
- R9: On a hit, match_ram holds the winning word with its key segments forced to zero and its payload segments as stored. On a miss, match_addr and match_ram are zero.
- R10: split_wr, mask_wr and cmpd_wr load split_in, mask_in and cmpd_in at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_wr | input | 1 | Load strobe for the split code |
| split_in | input | 3 | Split code: number of key segments |
| mask_wr | input | 1 | Load strobe for the care mask |
| mask_in | input | 64 | Care mask, 1 = bit compared |
| cmpd_wr | input | 1 | Load strobe for the search key |
| cmpd_in | input | 64 | Search key |
| cmp_go | input | 1 | Search strobe |
| wr_en | input | 1 | Word write enable |
| wr_addr | input | 4 | Word write index |
| wr_data | input | 64 | Word write data |
| wr_valid | input | 1 | Valid flag written with the word |
| rd_addr | input | 4 | Word read index |
| rd_data | output | 64 | Stored word at rd_addr |
| rd_valid | output | 1 | Valid flag at rd_addr |
| match | output | 1 | At least one valid word hit |
| multi | output | 1 | Two or more valid words hit |
| match_addr | output | 4 | Lowest hitting index |
| match_ram | output | 64 | Payload segments of the winning word |

## Verification
Corrupted state in this block shows up at the ports one cycle after the search strobe that uses it. A stuck valid bit makes an invalid word hit, or makes a stored word vanish. A wrong split decode turns payload bits into key bits, which changes the hit, and it also leaves nonzero bits in the cleared part of match_ram. A damaged mask register shows up as a miss where a hit is expected. A faulty priority path shows as a higher index or a missing multi flag, and both appear in the same cycle as the hit flag. Table contents can also be read straight back through the read port one cycle after the write.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int SEG_W  = 16;
    localparam int NSEG   = 4;
    localparam int WORD_W = SEG_W * NSEG;
    localparam int CODE_W = 3;

    // Number of key segments selected by a split code; out-of-range codes clamp.
    function automatic int unsigned key_segs(input logic [CODE_W-1:0] code);
        if (code == '0)
            return 1;
        else if (int'(code) > NSEG)
            return NSEG;
        else
            return int'(code);
    endfunction

    // Ones over the key segments (the most significant ones), zeros over payload.
    function automatic logic [WORD_W-1:0] key_field(input logic [CODE_W-1:0] code);
        logic [WORD_W-1:0] f;
        int unsigned n;
        n = key_segs(code);
        f = '0;
        for (int s = 0; s < NSEG; s++) begin
            if (s >= NSEG - int'(n))
                f[s*SEG_W +: SEG_W] = '1;
        end
        return f;
    endfunction
endpackage

// File: rtl/cam_match_line.sv
module cam_match_line
    import cam_pkg::*;
(
    input  logic [WORD_W-1:0] entry,
    input  logic              entry_vld,
    input  logic [WORD_W-1:0] key,
    input  logic [WORD_W-1:0] care,
    output logic              hit
);
    always_comb begin
        hit = entry_vld && (((entry ^ key) & care) == '0);
    end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic          many,
    output logic [AW-1:0] idx
);
    always_comb begin
        any  = 1'b0;
        many = 1'b0;
        idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                idx = AW'(i);
        end
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                if (any)
                    many = 1'b1;
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cam_partitioned.sv
module cam_partitioned
    import cam_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split_wr,
    input  logic [CODE_W-1:0] split_in,
    input  logic              mask_wr,
    input  logic [WORD_W-1:0] mask_in,
    input  logic              cmpd_wr,
    input  logic [WORD_W-1:0] cmpd_in,
    input  logic              cmp_go,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_valid,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              match,
    output logic              multi,
    output logic [AW-1:0]     match_addr,
    output logic [WORD_W-1:0] match_ram
);
    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [DEPTH-1:0]             vld;
        logic [WORD_W-1:0]            mask;
        logic [WORD_W-1:0]            cmpd;
        logic [CODE_W-1:0]            split;
        logic                         hit;
        logic                         multi;
        logic [AW-1:0]                addr;
        logic [WORD_W-1:0]            ram;
    } state_t;

    state_t state_d, state_q;

    logic [WORD_W-1:0] key_bits;
    logic [WORD_W-1:0] care;
    logic [DEPTH-1:0]  hits;
    logic              any_hit;
    logic              many_hit;
    logic [AW-1:0]     win_idx;
    logic [CODE_W-1:0] split_q;

    assign split_q  = state_q.split;
    assign key_bits = key_field(state_q.split);
    assign care     = key_bits & state_q.mask;

    for (genvar g = 0; g < DEPTH; g++) begin : g_line
        cam_match_line u_line (
            .entry    (state_q.mem[g]),
            .entry_vld(state_q.vld[g]),
            .key      (state_q.cmpd),
            .care     (care),
            .hit      (hits[g])
        );
    end

    cam_prio_enc #(.N(DEPTH), .AW(AW)) u_prio (
        .req (hits),
        .any (any_hit),
        .many(many_hit),
        .idx (win_idx)
    );

    always_comb begin
        state_d = state_q;
        if (split_wr)
            state_d.split = split_in;
        if (mask_wr)
            state_d.mask = mask_in;
        if (cmpd_wr)
            state_d.cmpd = cmpd_in;
        if (wr_en) begin
            state_d.mem[wr_addr] = wr_data;
            state_d.vld[wr_addr] = wr_valid;
        end
        if (cmp_go) begin
            state_d.hit   = any_hit;
            state_d.multi = many_hit;
            state_d.addr  = any_hit ? win_idx : '0;
            state_d.ram   = any_hit ? (state_q.mem[win_idx] & ~key_bits) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.mask  <= '1;
            state_q.split <= CODE_W'(NSEG);
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data    = state_q.mem[rd_addr];
    assign rd_valid   = state_q.vld[rd_addr];
    assign match      = state_q.hit;
    assign multi      = state_q.multi;
    assign match_addr = state_q.addr;
    assign match_ram  = state_q.ram;
endmodule

// File: rtl/cam_checker.sv
module cam_checker
    import cam_pkg::*;
#(
    parameter int AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_go,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              wr_valid,
    input logic [AW-1:0]     rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              match,
    input logic              multi,
    input logic [AW-1:0]     match_addr,
    input logic [WORD_W-1:0] match_ram,
    input logic [CODE_W-1:0] split_q
);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_go |=> ($stable(match) && $stable(multi) && $stable(match_addr) && $stable(match_ram)));

    p_multi_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        multi |-> match);

    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> (match_addr == '0 && match_ram == '0));

    p_key_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmp_go) |-> ((match_ram & key_field($past(split_q))) == '0));

    p_write_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_addr == wr_addr) |=>
            (!$stable(rd_addr) || (rd_data == $past(wr_data) && rd_valid == $past(wr_valid))));
endmodule

bind cam_partitioned cam_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_go    (cmp_go),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .match     (match),
    .multi     (multi),
    .match_addr(match_addr),
    .match_ram (match_ram),
    .split_q   (split_q)
);

// File: tb/cam_partitioned_bench.sv
module cam_partitioned_bench;
    import cam_pkg::*;

    localparam int AW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              split_wr = 1'b0;
    logic [CODE_W-1:0] split_in = '0;
    logic              mask_wr = 1'b0;
    logic [WORD_W-1:0] mask_in = '0;
    logic              cmpd_wr = 1'b0;
    logic [WORD_W-1:0] cmpd_in = '0;
    logic              cmp_go = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              wr_valid = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic [WORD_W-1:0] rd_data;
    logic              rd_valid;
    logic              match;
    logic              multi;
    logic [AW-1:0]     match_addr;
    logic [WORD_W-1:0] match_ram;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cam_partitioned u_cam_partitioned (
        .clk(clk), .rst_n(rst_n),
        .split_wr(split_wr), .split_in(split_in),
        .mask_wr(mask_wr), .mask_in(mask_in),
        .cmpd_wr(cmpd_wr), .cmpd_in(cmpd_in),
        .cmp_go(cmp_go),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_valid(wr_valid),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .match(match), .multi(multi), .match_addr(match_addr), .match_ram(match_ram)
    );

    typedef struct packed {
        logic [CODE_W-1:0] split;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] key;
        logic              e_hit;
        logic              e_multi;
        logic [AW-1:0]     e_addr;
        logic [WORD_W-1:0] e_ram;
    } vec_t;

    localparam logic [WORD_W-1:0] ONES = '1;

    localparam vec_t VECS [11] = '{
        '{3'd4, ONES, 64'h1111_2222_3333_4444, 1'b1, 1'b0, 4'd2, 64'h0},                     // R5 full key
        '{3'd2, ONES, 64'h1111_2222_0000_0000, 1'b1, 1'b1, 4'd2, 64'h0000_0000_3333_4444},   // R5 R7 R8 R9
        '{3'd1, ONES, 64'h1111_0000_0000_0000, 1'b1, 1'b1, 4'd2, 64'h0000_2222_3333_4444},   // R5 R8 R9
        '{3'd3, ONES, 64'h1111_2222_5555_0000, 1'b1, 1'b0, 4'd5, 64'h0000_0000_0000_6666},   // R5 R9
        '{3'd4, 64'h0000_FFFF_FFFF_0000, 64'h0000_2222_3333_0000, 1'b1, 1'b1, 4'd2, 64'h0},   // R6 R7
        '{3'd4, ONES, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 1'b0, 4'd0, 64'h0},                      // R4
        '{3'd0, ONES, 64'h7777_0000_0000_0000, 1'b1, 1'b0, 4'd9, 64'h0000_2222_3333_8888},   // R5 code 0
        '{3'd7, ONES, 64'h1111_2222_3333_0000, 1'b0, 1'b0, 4'd0, 64'h0},                      // R5 code 7
        '{3'd2, 64'hFFFF_0000_FFFF_FFFF, 64'h7777_1234_0000_0000, 1'b1, 1'b0, 4'd9, 64'h0000_0000_3333_8888}, // R6
        '{3'd5, ONES, 64'h1111_9999_0000_0001, 1'b1, 1'b0, 4'd12, 64'h0},                     // R5 code 5
        '{3'd4, 64'h0, 64'h0, 1'b1, 1'b1, 4'd2, 64'h0}                                        // R6 empty care
    };

    task automatic check(input string req, input string what,
                         input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_res(input string req, input logic h, input logic m,
                             input logic [AW-1:0] a, input logic [WORD_W-1:0] r);
        check(req, "match", WORD_W'(match), WORD_W'(h));
        check(req, "multi", WORD_W'(multi), WORD_W'(m));
        check(req, "match_addr", WORD_W'(match_addr), WORD_W'(a));
        check(req, "match_ram", match_ram, r);
    endtask

    // drive during the low phase, let one rising edge capture, sample at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        split_wr = 1'b0; mask_wr = 1'b0; cmpd_wr = 1'b0; cmp_go = 1'b0; wr_en = 1'b0;
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [WORD_W-1:0] d, input logic v);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_valid = v;
        step();
    endtask

    task automatic search(input logic [CODE_W-1:0] s, input logic [WORD_W-1:0] mk,
                          input logic [WORD_W-1:0] k);
        split_wr = 1'b1; split_in = s;
        mask_wr = 1'b1;  mask_in = mk;
        cmpd_wr = 1'b1;  cmpd_in = k;
        step();
        cmp_go = 1'b1;
        step();
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_addr = 4'd0;
        #1;
        check("R1", "rd_valid", WORD_W'(rd_valid), '0);
        check_res("R1", 1'b0, 1'b0, '0, '0);
        cmp_go = 1'b1;
        step();
        check_res("R1", 1'b0, 1'b0, '0, '0);
        // R1: mask resets to all ones and split to 4: entry differs only in the lowest byte
        put(4'd14, 64'h0000_0000_0000_00FF, 1'b1);
        cmp_go = 1'b1;
        step();
        check_res("R1", 1'b0, 1'b0, '0, '0);
        put(4'd14, 64'h0, 1'b0);

        // table contents
        put(4'd0,  64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
        put(4'd2,  64'h1111_2222_3333_4444, 1'b1);
        put(4'd5,  64'h1111_2222_5555_6666, 1'b1);
        put(4'd9,  64'h7777_2222_3333_8888, 1'b1);
        put(4'd12, 64'h1111_9999_0000_0001, 1'b1);

        // R2: readback
        rd_addr = 4'd5; #1;
        check("R2", "rd_data", rd_data, 64'h1111_2222_5555_6666);
        check("R2", "rd_valid", WORD_W'(rd_valid), 64'h1);
        rd_addr = 4'd0; #1;
        check("R2", "rd_data", rd_data, 64'hAAAA_BBBB_CCCC_DDDD);
        check("R2", "rd_valid", WORD_W'(rd_valid), 64'h0);

        // vector table: R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < 11; i++) begin
            search(VECS[i].split, VECS[i].mask, VECS[i].key);
            check_res($sformatf("R5/R6/R7/R8/R9 vec%0d", i),
                      VECS[i].e_hit, VECS[i].e_multi, VECS[i].e_addr, VECS[i].e_ram);
        end

        // R3: results hold while key and table change without a strobe
        cmpd_wr = 1'b1; cmpd_in = 64'hDEAD_BEEF_0000_0000;
        step();
        put(4'd2, 64'h0, 1'b0);
        check_res("R3 hold", 1'b1, 1'b1, 4'd2, 64'h0);

        // R3: a write at the same edge as the strobe is not seen by that search
        split_wr = 1'b1; split_in = 3'd4;
        mask_wr = 1'b1;  mask_in = ONES;
        cmpd_wr = 1'b1;  cmpd_in = 64'h5A5A_0000_0000_0001;
        step();
        cmp_go = 1'b1;
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 64'h5A5A_0000_0000_0001; wr_valid = 1'b1;
        step();
        check_res("R3 same-edge", 1'b0, 1'b0, '0, '0);
        cmp_go = 1'b1;
        step();
        check_res("R3 next search", 1'b1, 1'b0, 4'd1, 64'h0);

        // R4: invalidating the winner removes it
        put(4'd1, 64'h5A5A_0000_0000_0001, 1'b0);
        cmp_go = 1'b1;
        step();
        check_res("R4 invalidated", 1'b0, 1'b0, '0, '0);

        // R10: key load with split 1 and partial mask, entry 12 upper segment 1111
        search(3'd1, 64'h0FFF_0000_0000_0000, 64'hF111_0000_0000_0000);
        check_res("R10", 1'b1, 1'b1, 4'd5, 64'h0000_2222_5555_6666);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule